// File: doc/BRIEF.md
# Receive Sample-Delay Calibrator

This block picks the delay at which a source-synchronous card interface samples its incoming data. Once card bring-up is finished it walks every candidate delay in turn, from the smallest upward. At each step it drives the candidate onto the delay line and has an external command engine read the card's identification register and its card-specific-data register, alternating between the two. A candidate passes only if a programmable number of reads in a row return good CRC.

After the last candidate, the block records the lowest and highest passing delays. It then loads the rounded-up midpoint of that window into the delay output. If nothing passed, it raises a failure flag and keeps the delay it had before.

The same sweep starts again automatically when the command engine reports a response timeout or a CRC error in normal traffic. This lets a deliberately wrong starting delay recover by itself, and it follows drift in the sampling point with temperature. While a sweep runs, the block reports busy and turns away ordinary data requests.

Top module: `sdrx_lag_cal`

## Requirements
- R1: A pulse on start_i while idle begins a sweep. busy_o is high from the next clock edge until the sweep completes, and start_i also arms the automatic triggers.
- R2: A pulse on crc_err_i or timeout_i starts a sweep only once start_i has been seen since reset. Any trigger that arrives while busy_o is high is ignored.
- R3: A sweep visits the candidate delays 0 to 15 in ascending order. During the sweep, lag_o shows the candidate under test.
- R4: Each read is a one-cycle pulse on cmd_req_o, and the next pulse waits for cmd_done_i. At every candidate the first read uses command index 10 (identification register), and the index then alternates with 9 (card-specific data).
- R5: A candidate passes only if N consecutive reads return cmd_crc_ok_i high. N is taken from reads_i when the sweep starts, and a value of 0 behaves as 1. The first failing read ends that candidate at once.
- R6: After a successful sweep, lag_lo_o and lag_hi_o hold the lowest and highest passing candidates.
- R7: After a successful sweep, lag_sel_o and lag_o equal (lowest + highest + 1) / 2, rounded down, so an odd sum rounds up (6 and 8 give 7; 6 and 7 give 7). fail_o is then low.
- R8: If no candidate passes, fail_o goes high and lag_o keeps its value from before the sweep. lag_o does not change while the block is idle.
- R9: data_gnt_o follows data_req_i while idle and stays low while busy_o is high.
- R10: After reset, busy_o, fail_o and cmd_req_o are low and lag_o equals the LAG_INIT parameter (default 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a sweep after card bring-up; arms the automatic triggers |
| crc_err_i | input | 1 | CRC error seen in normal operation |
| timeout_i | input | 1 | Response timeout seen in normal operation |
| reads_i | input | 4 | Consecutive good reads needed per candidate |
| data_req_i | input | 1 | Normal data request |
| data_gnt_o | output | 1 | Data request accepted |
| cmd_req_o | output | 1 | One-cycle read request to the command engine |
| cmd_idx_o | output | 6 | Command index for the read (10 or 9) |
| cmd_done_i | input | 1 | Command engine finished the read |
| cmd_crc_ok_i | input | 1 | Response CRC was good, valid with cmd_done_i |
| lag_o | output | 4 | Delay driven to the sampling delay line |
| lag_lo_o | output | 4 | Lowest passing candidate |
| lag_hi_o | output | 4 | Highest passing candidate |
| lag_sel_o | output | 4 | Selected delay |
| busy_o | output | 1 | Sweep in progress |
| fail_o | output | 1 | Last sweep found no passing candidate |

## Verification
The modelled card passes a band of delays. The band is varied across three-wide and two-wide windows, so the midpoint is exercised with both even and odd sums. It is also placed on single delays at both ends of the range, across the full range, and as an empty band that must leave the old delay and raise the failure flag.

A flaky variant makes the lowest delay fail only on its fourth read. Running it with four reads and with three reads separates a design that demands every read from one that stops early on success. The number of requests issued per sweep shows whether failing candidates are abandoned on their first bad read.

Sweeps are started from each of the three trigger inputs. Triggers are also applied before arming and during a sweep, to show which of them are honoured.

// File: rtl/sdcal_pkg.sv
`timescale 1ns/1ps
package sdcal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } cal_state_e;

  localparam int unsigned CMD_W = 6;
  localparam logic [CMD_W-1:0] CMD_READ_ID  = 6'd10;
  localparam logic [CMD_W-1:0] CMD_READ_CSD = 6'd9;
endpackage

// File: rtl/cal_trigger.sv
`timescale 1ns/1ps
module cal_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_i,
  input  logic start_i,
  input  logic crc_err_i,
  input  logic timeout_i,
  output logic go_o,
  output logic armed_o
);
  logic armed_q, armed_d, armed_en;

  always_comb begin
    armed_en = start_i & ~armed_q;
    armed_d  = 1'b1;
    go_o     = idle_i & (start_i | (armed_q & (crc_err_i | timeout_i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

  assign armed_o = armed_q;

  // R2
  err_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_o && !start_i) |-> armed_q);
endmodule

// File: rtl/cal_read_seq.sv
`timescale 1ns/1ps
module cal_read_seq
  import sdcal_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reads_i,
  input  logic             next_lag_i,
  input  logic             inc_i,
  output logic             last_o,
  output logic [CMD_W-1:0] idx_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] nlast_q, nlast_d, cnt_q, cnt_d;
  logic             nlast_en, cnt_en;

  always_comb begin
    nlast_en = load_i;
    nlast_d  = (reads_i == '0) ? '0 : (reads_i - CNT_ONE);
    cnt_en   = load_i | next_lag_i | inc_i;
    cnt_d    = inc_i ? (cnt_q + CNT_ONE) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        nlast_q <= '0;
    else if (nlast_en) nlast_q <= nlast_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == nlast_q);
  assign idx_o  = cnt_q[0] ? CMD_READ_CSD : CMD_READ_ID;

  // R5
  rd_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= nlast_q);
endmodule

// File: rtl/cal_window.sv
`timescale 1ns/1ps
module cal_window #(
  parameter int unsigned LAG_W    = 4,
  parameter int unsigned LAG_INIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             pass_i,
  input  logic [LAG_W-1:0] cand_i,
  input  logic             commit_i,
  output logic [LAG_W-1:0] lo_o,
  output logic [LAG_W-1:0] hi_o,
  output logic             found_o,
  output logic [LAG_W-1:0] sel_o
);
  localparam logic [LAG_W:0] SUM_ONE = {{LAG_W{1'b0}}, 1'b1};

  logic [LAG_W-1:0] lo_q, lo_d, hi_q, hi_d, sel_q, sel_d;
  logic             found_q, found_d;
  logic             lo_en, hi_en, found_en, sel_en;
  logic [LAG_W:0]   sum;

  always_comb begin
    found_en = clr_i | pass_i;
    found_d  = ~clr_i;
    lo_en    = pass_i & ~found_q;
    lo_d     = cand_i;
    hi_en    = pass_i;
    hi_d     = cand_i;
    sum      = {1'b0, lo_q} + {1'b0, hi_q} + SUM_ONE;
    sel_en   = commit_i & found_q;
    sel_d    = sum[LAG_W:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        found_q <= 1'b0;
    else if (found_en) found_q <= found_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_en) lo_q <= lo_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_en) hi_q <= hi_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= LAG_W'(LAG_INIT);
    else if (sel_en) sel_q <= sel_d;
  end

  assign lo_o    = lo_q;
  assign hi_o    = hi_q;
  assign found_o = found_q;
  assign sel_o   = sel_q;

  // R6
  window_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found_q |-> (lo_q <= hi_q));

  // R7
  sel_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && found_q) |=> ((sel_q >= lo_q) && (sel_q <= hi_q)));
endmodule

// File: rtl/sdrx_lag_cal.sv
`timescale 1ns/1ps
module sdrx_lag_cal
  import sdcal_pkg::*;
#(
  parameter int unsigned LAG_W    = 4,
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned LAG_INIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             crc_err_i,
  input  logic             timeout_i,
  input  logic [CNT_W-1:0] reads_i,
  input  logic             data_req_i,
  output logic             data_gnt_o,
  output logic             cmd_req_o,
  output logic [CMD_W-1:0] cmd_idx_o,
  input  logic             cmd_done_i,
  input  logic             cmd_crc_ok_i,
  output logic [LAG_W-1:0] lag_o,
  output logic [LAG_W-1:0] lag_lo_o,
  output logic [LAG_W-1:0] lag_hi_o,
  output logic [LAG_W-1:0] lag_sel_o,
  output logic             busy_o,
  output logic             fail_o
);
  localparam logic [LAG_W-1:0] LAG_LAST = '1;
  localparam logic [LAG_W-1:0] LAG_ONE  = {{(LAG_W-1){1'b0}}, 1'b1};

  cal_state_e       st_q, st_d;
  logic [LAG_W-1:0] cand_q, cand_d;
  logic             cand_en;
  logic             fail_q, fail_d, fail_en;
  logic             idle, go, armed;
  logic             rd_last, rd_inc, rd_next_lag;
  logic             resp, resp_ok, lag_end, lag_pass;
  logic             commit, found;
  logic [LAG_W-1:0] sel;

  assign idle = (st_q == ST_IDLE);

  cal_trigger u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_i    (idle),
    .start_i   (start_i),
    .crc_err_i (crc_err_i),
    .timeout_i (timeout_i),
    .go_o      (go),
    .armed_o   (armed)
  );

  cal_read_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (go),
    .reads_i    (reads_i),
    .next_lag_i (rd_next_lag),
    .inc_i      (rd_inc),
    .last_o     (rd_last),
    .idx_o      (cmd_idx_o)
  );

  cal_window #(.LAG_W(LAG_W), .LAG_INIT(LAG_INIT)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (go),
    .pass_i   (lag_pass),
    .cand_i   (cand_q),
    .commit_i (commit),
    .lo_o     (lag_lo_o),
    .hi_o     (lag_hi_o),
    .found_o  (found),
    .sel_o    (sel)
  );

  always_comb begin
    resp        = (st_q == ST_WAIT) & cmd_done_i;
    resp_ok     = resp & cmd_crc_ok_i;
    rd_inc      = resp_ok & ~rd_last;
    lag_end     = resp & ~(cmd_crc_ok_i & ~rd_last);
    lag_pass    = resp_ok & rd_last;
    rd_next_lag = lag_end & (cand_q != LAG_LAST);
    commit      = (st_q == ST_DONE);

    st_d    = st_q;
    cand_en = 1'b0;
    cand_d  = cand_q;
    unique case (st_q)
      ST_IDLE: if (go) begin
        st_d    = ST_REQ;
        cand_en = 1'b1;
        cand_d  = '0;
      end
      ST_REQ:  st_d = ST_WAIT;
      ST_WAIT: begin
        if (rd_inc) st_d = ST_REQ;
        else if (lag_end) begin
          if (cand_q == LAG_LAST) st_d = ST_DONE;
          else begin
            st_d    = ST_REQ;
            cand_en = 1'b1;
            cand_d  = cand_q + LAG_ONE;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase

    fail_en = commit;
    fail_d  = ~found;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cand_q <= '0;
    else if (cand_en) cand_q <= cand_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fail_q <= 1'b0;
    else if (fail_en) fail_q <= fail_d;
  end

  assign busy_o     = ~idle;
  assign cmd_req_o  = (st_q == ST_REQ);
  assign lag_o      = idle ? sel : cand_q;
  assign lag_sel_o  = sel;
  assign fail_o     = fail_q;
  assign data_gnt_o = data_req_i & idle;

  // R4
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req_o |=> !cmd_req_o);

  // R4
  cmd_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req_o |-> ((cmd_idx_o == CMD_READ_ID) || (cmd_idx_o == CMD_READ_CSD)));

  // R3
  sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && (lag_o != $past(lag_o))) |-> (lag_o == ($past(lag_o) + LAG_ONE)));

  // R2
  busy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i || (armed && (crc_err_i || timeout_i))));

  // R8
  idle_lag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> $stable(lag_o));

  // R8
  fail_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fail_o) |-> $past(busy_o));
endmodule

// File: tb/test_sdrx_lag_cal.sv
`timescale 1ns/1ps
module test_sdrx_lag_cal;
  logic       clk, rst_n;
  logic       start_i, crc_err_i, timeout_i;
  logic [3:0] reads_i;
  logic       data_req_i, data_gnt_o;
  logic       cmd_req_o;
  logic [5:0] cmd_idx_o;
  logic       cmd_done_i, cmd_crc_ok_i;
  logic [3:0] lag_o, lag_lo_o, lag_hi_o, lag_sel_o;
  logic       busy_o, fail_o;

  int checks = 0, errors = 0;
  int wlo = 15, whi = 0, flaky = 0;
  int req_cnt, idx_err, seq_err, prev_lag, rd_in_lag;

  // {wlo, whi, reads, flaky, exp_fail, exp_lo, exp_hi, exp_sel}
  localparam logic [25:0] VEC [10] = '{
    {4'd6,  4'd8,  4'd4, 1'b0, 1'b0, 4'd6,  4'd8,  4'd7},
    {4'd6,  4'd7,  4'd4, 1'b0, 1'b0, 4'd6,  4'd7,  4'd7},
    {4'd0,  4'd0,  4'd2, 1'b0, 1'b0, 4'd0,  4'd0,  4'd0},
    {4'd15, 4'd15, 4'd4, 1'b0, 1'b0, 4'd15, 4'd15, 4'd15},
    {4'd0,  4'd15, 4'd1, 1'b0, 1'b0, 4'd0,  4'd15, 4'd8},
    {4'd3,  4'd12, 4'd4, 1'b0, 1'b0, 4'd3,  4'd12, 4'd8},
    {4'd15, 4'd0,  4'd4, 1'b0, 1'b1, 4'd0,  4'd0,  4'd8},
    {4'd2,  4'd4,  4'd1, 1'b0, 1'b0, 4'd2,  4'd4,  4'd3},
    {4'd5,  4'd9,  4'd4, 1'b1, 1'b0, 4'd6,  4'd9,  4'd8},
    {4'd5,  4'd9,  4'd3, 1'b1, 1'b0, 4'd5,  4'd9,  4'd7}
  };

  sdrx_lag_cal i_sdrx_lag_cal (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .crc_err_i(crc_err_i),
    .timeout_i(timeout_i), .reads_i(reads_i), .data_req_i(data_req_i),
    .data_gnt_o(data_gnt_o), .cmd_req_o(cmd_req_o), .cmd_idx_o(cmd_idx_o),
    .cmd_done_i(cmd_done_i), .cmd_crc_ok_i(cmd_crc_ok_i), .lag_o(lag_o),
    .lag_lo_o(lag_lo_o), .lag_hi_o(lag_hi_o), .lag_sel_o(lag_sel_o),
    .busy_o(busy_o), .fail_o(fail_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_reqs(input int lo, input int hi, input int n, input int fl);
    int nn = (n == 0) ? 1 : n;
    int tot = 0;
    for (int l = 0; l < 16; l++) begin
      if (l >= lo && l <= hi) tot += (fl != 0 && l == lo && nn >= 4) ? 4 : nn;
      else tot += 1;
    end
    return tot;
  endfunction

  // Command engine model: answers each request two cycles later.
  initial begin
    cmd_done_i = 1'b0;
    cmd_crc_ok_i = 1'b0;
    forever begin
      @(negedge clk);
      cmd_done_i = 1'b0;
      cmd_crc_ok_i = 1'b0;
      if (rst_n && cmd_req_o) begin
        bit ok;
        req_cnt++;
        if (int'(lag_o) != prev_lag) begin
          if (int'(lag_o) != prev_lag + 1) seq_err++;
          prev_lag = int'(lag_o);
          rd_in_lag = 0;
        end
        if (cmd_idx_o != ((rd_in_lag % 2 == 0) ? 6'd10 : 6'd9)) idx_err++;
        ok = (int'(lag_o) >= wlo) && (int'(lag_o) <= whi) &&
             !(flaky != 0 && int'(lag_o) == wlo && rd_in_lag == 3);
        rd_in_lag++;
        @(negedge clk);
        @(negedge clk);
        cmd_done_i = 1'b1;
        cmd_crc_ok_i = ok;
      end
    end
  end

  // trig: 0 start, 1 crc error, 2 timeout
  task automatic run_cal(input int trig, input string req);
    int cyc = 0;
    req_cnt = 0; idx_err = 0; seq_err = 0; prev_lag = -1; rd_in_lag = 0;
    @(negedge clk);
    if (trig == 0) start_i = 1'b1;
    else if (trig == 1) crc_err_i = 1'b1;
    else timeout_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; crc_err_i = 1'b0; timeout_i = 1'b0;
    chk(busy_o == 1'b1, req, busy_o, 1);
    while (busy_o && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    chk(busy_o == 1'b0, "watchdog R1", busy_o, 0);
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; crc_err_i = 1'b0; timeout_i = 1'b0;
    reads_i = 4'd4; data_req_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(busy_o == 0, "R10 busy", busy_o, 0);
    chk(fail_o == 0, "R10 fail", fail_o, 0);
    chk(cmd_req_o == 0, "R10 req", cmd_req_o, 0);
    chk(lag_o == 4'd0, "R10 lag", lag_o, 0);

    // R2: errors before arming are ignored
    crc_err_i = 1'b1; timeout_i = 1'b1;
    @(negedge clk);
    crc_err_i = 1'b0; timeout_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && lag_o == 4'd0, "R2 unarmed", busy_o, 0);

    // R9 grant while idle
    data_req_i = 1'b1;
    @(negedge clk);
    chk(data_gnt_o == 1'b1, "R9 idle grant", data_gnt_o, 1);

    // Vector table
    for (int v = 0; v < 10; v++) begin
      logic [25:0] e = VEC[v];
      wlo = int'(e[25:22]); whi = int'(e[21:18]); reads_i = e[17:14];
      flaky = int'(e[13]);
      run_cal(0, "R1 start");
      chk(fail_o == e[12], "R8 fail flag", fail_o, e[12]);
      if (!e[12]) begin
        chk(lag_lo_o == e[11:8], "R6 lo", lag_lo_o, e[11:8]);
        chk(lag_hi_o == e[7:4], "R6 hi", lag_hi_o, e[7:4]);
      end
      chk(lag_sel_o == e[3:0], "R7 sel", lag_sel_o, e[3:0]);
      chk(lag_o == e[3:0], "R7 R8 lag", lag_o, e[3:0]);
      chk(req_cnt == exp_reqs(wlo, whi, int'(reads_i), flaky), "R5 reads",
          req_cnt, exp_reqs(wlo, whi, int'(reads_i), flaky));
      chk(idx_err == 0, "R4 index order", idx_err, 0);
      chk(seq_err == 0 && prev_lag == 15, "R3 sweep", prev_lag, 15);
    end

    // R5: reads_i of zero acts as one
    wlo = 6; whi = 8; flaky = 0; reads_i = 4'd0;
    run_cal(0, "R1 start");
    chk(req_cnt == 16, "R5 zero reads", req_cnt, 16);
    chk(lag_o == 4'd7, "R7 lag", lag_o, 7);

    // R2: timeout triggers after arming
    wlo = 10; whi = 13; reads_i = 4'd4;
    run_cal(2, "R2 timeout trig");
    chk(lag_o == 4'd12, "R2 R7 timeout result", lag_o, 12);

    // R2: CRC error triggers; R9 grant refused while busy; mid-sweep trigger ignored
    wlo = 1; whi = 3;
    req_cnt = 0; idx_err = 0; seq_err = 0; prev_lag = -1; rd_in_lag = 0;
    @(negedge clk);
    crc_err_i = 1'b1;
    @(negedge clk);
    crc_err_i = 1'b0;
    chk(busy_o == 1'b1, "R2 crc trig", busy_o, 1);
    chk(data_gnt_o == 1'b0, "R9 busy refuse", data_gnt_o, 0);
    repeat (10) @(negedge clk);
    timeout_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    timeout_i = 1'b0; start_i = 1'b0;
    for (int c = 0; c < 5000 && busy_o; c++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(busy_o == 1'b0, "R2 busy trig ignored", busy_o, 0);
    chk(lag_o == 4'd2, "R7 crc result", lag_o, 2);
    chk(req_cnt == exp_reqs(1, 3, 4, 0), "R2 single sweep", req_cnt, exp_reqs(1, 3, 4, 0));
    chk(data_gnt_o == 1'b1, "R9 grant after", data_gnt_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule